// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point result held in a wide internal form and turns it into a 32-bit IEEE single-precision word. The internal form has a class tag, a sign, a signed unbiased exponent, a left-aligned significand and a sticky bit. The significand carries an explicit leading one, followed by the fraction and any number of extra low bits. The block biases the exponent and rounds to 24 significant bits in one of four directed modes. It handles values too small for a normal encoding by denormalising them, and values too large by saturating them. Four status conditions are reported: invalid-operand, overflow, underflow and inexact.

An operation is accepted on any clock edge where `op_start` is high. Its packed word and a one-cycle valid strobe appear on the outputs after that edge. Status conditions are OR-accumulated into a flag register. Software-side logic clears this register with `flag_clr`, normally in the same cycle as the first operation of a sequence. When clear and start coincide, the clear is applied first and the new operation's flags are then merged in.

Top module: `sp_packer`

## Requirements
- R1: Class encodings are zero=0, normal number=1, infinity=2, NaN=3. A zero packs as the sign bit alone, and an infinity packs as the sign, exponent field 255 and a zero fraction. Neither raises a flag.
- R2: A NaN packs with its sign, exponent field 255, and the 23 significand bits just below the leading-one position as its fraction. It raises no flag.
- R3: A normal number packs with exponent field equal to the unbiased exponent plus 127. The fraction field holds the 23 bits after the leading one, and the output word is {sign, exponent[7:0], fraction[22:0]}.
- R4: Rounding uses guard, round and sticky. Mode encodings are nearest-even=0, toward zero=1, toward minus infinity=2 and toward plus infinity=3. Nearest-even rounds up when guard is set and round, sticky or the kept LSB is set. Toward zero never rounds up. Each infinity direction rounds up on any lost bit only for values of its own sign.
- R5: When rounding carries the significand to 2.0, the exponent field rises by one and the fraction field becomes zero.
- R6: A final exponent field of 255 or more sets the invalid-operand, overflow and inexact flags together. Flag bit order is {invalid, overflow, underflow, inexact} = bits 3..0.
- R7: On overflow the result is an infinity in nearest-even mode, and the largest finite value (exponent field 254, fraction all ones) in toward-zero mode. In toward-plus-infinity mode it is an infinity only for positive values, and in toward-minus-infinity mode only for negative values.
- R8: A biased exponent of zero or below sets underflow. The significand is then shifted right by one minus the biased exponent and packed with exponent field 0. If rounding carries into the leading position, the result is the smallest normal (exponent field 1, fraction 0).
- R9: Inexact is set whenever any guard, round or sticky bit is lost, including when rounding goes down.
- R10: Flags accumulate by OR across operations. They hold while neither start nor clear is high, and `flag_clr` empties them before the same cycle's operation is merged in.
- R11: The result and its valid strobe appear one clock after the start edge. Without a start, valid is low and the result word holds.
- R12: After reset the result word, valid and flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | Accept the operand on this edge |
| flag_clr | input | 1 | Empty the flag register on this edge |
| op_class | input | 2 | Operand class tag |
| op_sign | input | 1 | Operand sign |
| op_exp | input | EXP_W | Signed unbiased exponent |
| op_mant | input | MANT_W | Significand, leading one at MSB |
| op_sticky | input | 1 | OR of bits already discarded below the significand |
| rnd_mode | input | 2 | Rounding direction |
| res_word | output | 32 | Packed single-precision word |
| res_valid | output | 1 | One-cycle strobe for a new result |
| exc_flags | output | 4 | Accumulated status flags |

## Verification
The bench builds the packer with its default widths: a 32-bit significand and a 10-bit signed exponent. The eight low significand bits then map directly onto guard, round and sticky, so every rounding tie and carry can be placed exactly with hex operands. The exponent range reaches well past the overflow threshold and far below the denormal range, down to -400. This exercises the capped shift, the promotion of a rounded subnormal, and each overflow target under all four modes and both signs.

// File: rtl/sp_pack_pkg.sv
package sp_pack_pkg;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NUM  = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } op_class_e;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_ZERO    = 2'd1,
        RM_DOWN    = 2'd2,
        RM_UP      = 2'd3
    } rnd_mode_e;

    localparam int FRAC_W     = 23;
    localparam int SIG_W      = FRAC_W + 1;
    localparam int EXPF_W     = 8;
    localparam int EXP_BIAS   = 127;
    localparam int EXPF_TOP   = (1 << EXPF_W) - 1;
    localparam int DENORM_CAP = SIG_W + 2;

    localparam int FLG_INEX  = 0;
    localparam int FLG_UNFL  = 1;
    localparam int FLG_OVFL  = 2;
    localparam int FLG_OPERR = 3;
    localparam int FLG_W     = 4;

    typedef struct packed {
        logic [31:0]      word;
        logic             valid;
        logic [FLG_W-1:0] flags;
    } pack_state_t;

endpackage

// File: rtl/sp_align.sv
module sp_align
    import sp_pack_pkg::*;
#(
    parameter int MANT_W = 32,
    parameter int SH_W   = 5
) (
    input  logic [MANT_W-1:0] mant,
    input  logic              sticky_in,
    input  logic [SH_W-1:0]   sh,
    output logic [SIG_W-1:0]  sig,
    output logic              guard,
    output logic              rnd,
    output logic              sticky
);
    localparam int W = MANT_W + DENORM_CAP;

    logic [W-1:0] wide;

    always_comb begin
        wide   = {mant, {DENORM_CAP{1'b0}}} >> sh;
        sig    = wide[W-1 -: SIG_W];
        guard  = wide[W-SIG_W-1];
        rnd    = wide[W-SIG_W-2];
        sticky = (|wide[W-SIG_W-3:0]) | sticky_in;
    end
endmodule

// File: rtl/sp_round_unit.sv
module sp_round_unit
    import sp_pack_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       sign,
    input  logic       lsb,
    input  logic       guard,
    input  logic       rnd,
    input  logic       sticky,
    output logic       inc,
    output logic       inexact
);
    always_comb begin
        inexact = guard | rnd | sticky;
        unique case (rnd_mode_e'(mode))
            RM_NEAREST: inc = guard & (rnd | sticky | lsb);
            RM_ZERO:    inc = 1'b0;
            RM_DOWN:    inc = sign & inexact;
            RM_UP:      inc = ~sign & inexact;
            default:    inc = 1'b0;
        endcase
    end
endmodule

// File: rtl/sp_ovf_select.sv
module sp_ovf_select
    import sp_pack_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       sign,
    output logic       to_inf
);
    always_comb begin
        unique case (rnd_mode_e'(mode))
            RM_NEAREST: to_inf = 1'b1;
            RM_ZERO:    to_inf = 1'b0;
            RM_UP:      to_inf = ~sign;
            RM_DOWN:    to_inf = sign;
            default:    to_inf = 1'b1;
        endcase
    end
endmodule

// File: rtl/sp_packer.sv
module sp_packer
    import sp_pack_pkg::*;
#(
    parameter int MANT_W = 32,
    parameter int EXP_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    op_start,
    input  logic                    flag_clr,
    input  logic [1:0]              op_class,
    input  logic                    op_sign,
    input  logic signed [EXP_W-1:0] op_exp,
    input  logic [MANT_W-1:0]       op_mant,
    input  logic                    op_sticky,
    input  logic [1:0]              rnd_mode,
    output logic [31:0]             res_word,
    output logic                    res_valid,
    output logic [3:0]              exc_flags
);
    localparam int BE_W = EXP_W + 2;
    localparam int SH_W = $clog2(DENORM_CAP + 1);

    pack_state_t st_d, st_q;

    logic signed [BE_W-1:0] biased_d;
    logic signed [BE_W-1:0] shift_full_d;
    logic signed [BE_W-1:0] exp_fin_d;
    logic                   is_sub_d;
    logic [SH_W-1:0]        sh_d;
    logic [SIG_W-1:0]       sig_d;
    logic                   g_d, r_d, s_d;
    logic                   inc_d, inexact_d, to_inf_d;
    logic [SIG_W:0]         rsig_d;
    logic [FLG_W-1:0]       new_flags_d;
    logic [31:0]            word_d;

    always_comb begin
        biased_d     = $signed({{2{op_exp[EXP_W-1]}}, op_exp}) + $signed(BE_W'(EXP_BIAS));
        is_sub_d     = (biased_d <= $signed(BE_W'(0)));
        shift_full_d = $signed(BE_W'(1)) - biased_d;
        if (!is_sub_d)
            sh_d = '0;
        else if (shift_full_d > $signed(BE_W'(DENORM_CAP)))
            sh_d = SH_W'(DENORM_CAP);
        else
            sh_d = shift_full_d[SH_W-1:0];
    end

    sp_align #(.MANT_W(MANT_W), .SH_W(SH_W)) u_align (
        .mant      (op_mant),
        .sticky_in (op_sticky),
        .sh        (sh_d),
        .sig       (sig_d),
        .guard     (g_d),
        .rnd       (r_d),
        .sticky    (s_d)
    );

    sp_round_unit u_round (
        .mode    (rnd_mode),
        .sign    (op_sign),
        .lsb     (sig_d[0]),
        .guard   (g_d),
        .rnd     (r_d),
        .sticky  (s_d),
        .inc     (inc_d),
        .inexact (inexact_d)
    );

    sp_ovf_select u_ovf (
        .mode   (rnd_mode),
        .sign   (op_sign),
        .to_inf (to_inf_d)
    );

    always_comb begin
        rsig_d      = {1'b0, sig_d} + (SIG_W+1)'(inc_d);
        exp_fin_d   = biased_d + $signed(BE_W'(rsig_d[SIG_W]));
        new_flags_d = '0;
        word_d      = '0;
        unique case (op_class_e'(op_class))
            CLS_ZERO: word_d = {op_sign, 31'd0};
            CLS_INF:  word_d = {op_sign, EXPF_W'(EXPF_TOP), {FRAC_W{1'b0}}};
            CLS_NAN:  word_d = {op_sign, EXPF_W'(EXPF_TOP), op_mant[MANT_W-2 -: FRAC_W]};
            default: begin
                if (is_sub_d) begin
                    new_flags_d[FLG_UNFL] = 1'b1;
                    new_flags_d[FLG_INEX] = inexact_d;
                    word_d = {op_sign, {(EXPF_W-1){1'b0}}, rsig_d[SIG_W-1], rsig_d[FRAC_W-1:0]};
                end else if (exp_fin_d >= $signed(BE_W'(EXPF_TOP))) begin
                    new_flags_d[FLG_OPERR] = 1'b1;
                    new_flags_d[FLG_OVFL]  = 1'b1;
                    new_flags_d[FLG_INEX]  = 1'b1;
                    if (to_inf_d)
                        word_d = {op_sign, EXPF_W'(EXPF_TOP), {FRAC_W{1'b0}}};
                    else
                        word_d = {op_sign, EXPF_W'(EXPF_TOP - 1), {FRAC_W{1'b1}}};
                end else begin
                    new_flags_d[FLG_INEX] = inexact_d;
                    word_d = {op_sign, exp_fin_d[EXPF_W-1:0], rsig_d[FRAC_W-1:0]};
                end
            end
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = op_start;
        if (flag_clr)
            st_d.flags = '0;
        if (op_start) begin
            st_d.word  = word_d;
            st_d.flags = st_d.flags | new_flags_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign res_word  = st_q.word;
    assign res_valid = st_q.valid;
    assign exc_flags = st_q.flags;

    assert_valid_follows_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> res_valid);
    assert_idle_no_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_start |=> !res_valid);
    assert_hold_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_start |=> $stable(res_word));
    assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_start && !flag_clr) |=> $stable(exc_flags));
    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !op_start) |=> (exc_flags == '0));
    assert_ovf_triple_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_flags[FLG_OVFL] |-> (exc_flags[FLG_OPERR] && exc_flags[FLG_INEX]));
    assert_nan_exp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_class == CLS_NAN) |=> (res_word[30:23] == 8'hFF));
    assert_special_no_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && flag_clr && (op_class == CLS_ZERO || op_class == CLS_INF))
        |=> (exc_flags == '0));
endmodule

// File: tb/sim_sp_packer.sv
module sim_sp_packer;
    typedef struct packed {
        logic [1:0]  cls;
        logic        sgn;
        logic [9:0]  e;
        logic [31:0] m;
        logic [1:0]  md;
        logic [31:0] w;
        logic [3:0]  f;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 31;
    // flags {invalid, overflow, underflow, inexact}; class 0 zero 1 num 2 inf 3 nan; mode 0 N 1 Z 2 D 3 U
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b0, 10'sd0,    32'h8000_0000, 2'd0, 32'h3F80_0000, 4'h0, 8'd3},  // R3
        '{2'd1, 1'b1, 10'sd1,    32'hC000_0000, 2'd0, 32'hC040_0000, 4'h0, 8'd3},  // R3
        '{2'd0, 1'b0, 10'sd0,    32'h0000_0000, 2'd0, 32'h0000_0000, 4'h0, 8'd1},  // R1
        '{2'd0, 1'b1, 10'sd0,    32'h0000_0000, 2'd0, 32'h8000_0000, 4'h0, 8'd1},  // R1
        '{2'd2, 1'b1, 10'sd0,    32'h0000_0000, 2'd0, 32'hFF80_0000, 4'h0, 8'd1},  // R1
        '{2'd3, 1'b0, 10'sd0,    32'hE000_0000, 2'd0, 32'h7FE0_0000, 4'h0, 8'd2},  // R2
        '{2'd1, 1'b0, 10'sd0,    32'h8000_0080, 2'd0, 32'h3F80_0000, 4'h1, 8'd4},  // R4 tie even
        '{2'd1, 1'b0, 10'sd0,    32'h8000_0080, 2'd3, 32'h3F80_0001, 4'h1, 8'd4},  // R4
        '{2'd1, 1'b0, 10'sd0,    32'h8000_0080, 2'd1, 32'h3F80_0000, 4'h1, 8'd4},  // R4
        '{2'd1, 1'b1, 10'sd0,    32'h8000_0080, 2'd2, 32'hBF80_0001, 4'h1, 8'd4},  // R4
        '{2'd1, 1'b0, 10'sd0,    32'h8000_0080, 2'd2, 32'h3F80_0000, 4'h1, 8'd4},  // R4
        '{2'd1, 1'b0, 10'sd0,    32'h8000_0180, 2'd0, 32'h3F80_0002, 4'h1, 8'd4},  // R4 tie odd
        '{2'd1, 1'b0, 10'sd0,    32'h8000_0040, 2'd0, 32'h3F80_0000, 4'h1, 8'd9},  // R9
        '{2'd1, 1'b0, 10'sd0,    32'h8000_00C0, 2'd0, 32'h3F80_0001, 4'h1, 8'd4},  // R4
        '{2'd1, 1'b0, 10'sd0,    32'hFFFF_FF80, 2'd0, 32'h4000_0000, 4'h1, 8'd5},  // R5
        '{2'd1, 1'b0, 10'sd127,  32'hFFFF_FF80, 2'd0, 32'h7F80_0000, 4'hD, 8'd6},  // R6
        '{2'd1, 1'b0, 10'sd127,  32'hFFFF_FF80, 2'd1, 32'h7F7F_FFFF, 4'h1, 8'd5},  // R5
        '{2'd1, 1'b0, 10'sd128,  32'h8000_0000, 2'd0, 32'h7F80_0000, 4'hD, 8'd7},  // R7
        '{2'd1, 1'b0, 10'sd128,  32'h8000_0000, 2'd1, 32'h7F7F_FFFF, 4'hD, 8'd7},  // R7
        '{2'd1, 1'b0, 10'sd128,  32'h8000_0000, 2'd3, 32'h7F80_0000, 4'hD, 8'd7},  // R7
        '{2'd1, 1'b1, 10'sd128,  32'h8000_0000, 2'd3, 32'hFF7F_FFFF, 4'hD, 8'd7},  // R7
        '{2'd1, 1'b1, 10'sd128,  32'h8000_0000, 2'd2, 32'hFF80_0000, 4'hD, 8'd7},  // R7
        '{2'd1, 1'b0, 10'sd128,  32'h8000_0000, 2'd2, 32'h7F7F_FFFF, 4'hD, 8'd7},  // R7
        '{2'd1, 1'b0, -10'sd127, 32'h8000_0000, 2'd0, 32'h0040_0000, 4'h2, 8'd8},  // R8
        '{2'd1, 1'b0, -10'sd149, 32'h8000_0000, 2'd0, 32'h0000_0001, 4'h2, 8'd8},  // R8
        '{2'd1, 1'b0, -10'sd150, 32'h8000_0000, 2'd0, 32'h0000_0000, 4'h3, 8'd8},  // R8
        '{2'd1, 1'b0, -10'sd150, 32'h8000_0000, 2'd3, 32'h0000_0001, 4'h3, 8'd8},  // R8
        '{2'd1, 1'b0, -10'sd150, 32'hC000_0000, 2'd0, 32'h0000_0001, 4'h3, 8'd8},  // R8
        '{2'd1, 1'b0, -10'sd127, 32'hFFFF_FF00, 2'd0, 32'h0080_0000, 4'h3, 8'd8},  // R8 promote
        '{2'd1, 1'b0, -10'sd400, 32'h8000_0000, 2'd0, 32'h0000_0000, 4'h3, 8'd8},  // R8
        '{2'd1, 1'b1, -10'sd400, 32'h8000_0000, 2'd2, 32'h8000_0001, 4'h3, 8'd8}   // R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_start = 1'b0;
    logic        flag_clr = 1'b0;
    logic [1:0]  op_class = '0;
    logic        op_sign = 1'b0;
    logic signed [9:0] op_exp = '0;
    logic [31:0] op_mant = '0;
    logic        op_sticky = 1'b0;
    logic [1:0]  rnd_mode = '0;
    logic [31:0] res_word;
    logic        res_valid;
    logic [3:0]  exc_flags;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sp_packer u0 (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .flag_clr(flag_clr),
        .op_class(op_class), .op_sign(op_sign), .op_exp(op_exp), .op_mant(op_mant),
        .op_sticky(op_sticky), .rnd_mode(rnd_mode), .res_word(res_word),
        .res_valid(res_valid), .exc_flags(exc_flags)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] c, input logic s, input logic [9:0] e,
                          input logic [31:0] m, input logic [1:0] md, input logic clr);
        @(negedge clk);
        op_class = c; op_sign = s; op_exp = e; op_mant = m; rnd_mode = md;
        op_start = 1'b1; flag_clr = clr;
        @(negedge clk);
        op_start = 1'b0; flag_clr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12 word", res_word, 32'h0);
        check("R12 valid", {31'd0, res_valid}, 32'h0);
        check("R12 flags", {28'd0, exc_flags}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].cls, VECS[i].sgn, VECS[i].e, VECS[i].m, VECS[i].md, 1'b1);
            check($sformatf("R%0d word v%0d", VECS[i].req, i), res_word, VECS[i].w);
            check($sformatf("R%0d flags v%0d", VECS[i].req, i), {28'd0, exc_flags}, {28'd0, VECS[i].f});
            check($sformatf("R11 valid v%0d", i), {31'd0, res_valid}, 32'h1);
        end

        // R11: idle cycle, valid drops and word holds
        @(negedge clk);
        check("R11 idle valid", {31'd0, res_valid}, 32'h0);
        check("R11 idle hold", res_word, VECS[NV-1].w);

        // R10: accumulation without clear
        run_op(2'd1, 1'b0, -10'sd150, 32'h8000_0000, 2'd0, 1'b1);
        check("R10 first", {28'd0, exc_flags}, 32'h3);
        run_op(2'd1, 1'b0, 10'sd128, 32'h8000_0000, 2'd0, 1'b0);
        check("R10 accum", {28'd0, exc_flags}, 32'hF);
        run_op(2'd1, 1'b0, 10'sd0, 32'h8000_0000, 2'd0, 1'b0);
        check("R10 exact keeps", {28'd0, exc_flags}, 32'hF);
        @(negedge clk);
        check("R10 hold idle", {28'd0, exc_flags}, 32'hF);

        // R10: clear alone
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check("R10 clear", {28'd0, exc_flags}, 32'h0);
        check("R11 clear no valid", {31'd0, res_valid}, 32'h0);

        // R9: sticky input alone makes result inexact
        op_sticky = 1'b1;
        run_op(2'd1, 1'b0, 10'sd0, 32'h8000_0000, 2'd3, 1'b1);
        op_sticky = 1'b0;
        check("R9 sticky word", res_word, 32'h3F80_0001);
        check("R9 sticky flag", {28'd0, exc_flags}, 32'h1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule